// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects up to eight interrupt request lines, ranks them, and raises one interrupt output toward a processor whenever an enabled request outranks everything currently being serviced. A processor programs it through a small byte-wide register port: one chip-select, one address bit and a write strobe. A start byte at the even address opens a short configuration sequence at the odd address (vector base, then the cascade byte, then the mode byte). After the sequence, odd-address writes load the mask and even-address writes are commands: end of interrupt, priority rotation and readback selection.

When the processor acknowledges with a one-cycle strobe, the controller picks the winning line, marks it in service and, one cycle later, presents the vector (base plus line number). Two controllers can be chained. A master reports the line number on a cascade output instead of a vector when that line has a slave behind it. A slave answers an acknowledge only when the cascade code it sees matches its programmed identity. Inputs may be edge or level sensitive. Service may end through explicit end-of-interrupt commands or automatically at acknowledge. The lowest-priority line can be moved so that service order rotates.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, and again after every start byte, the mask reads back 0xFF, the in-service set is empty, line 7 is lowest priority and `int_out` stays low. `int_out` also stays low until the configuration sequence completes.
- R2: Configuration begins with an even-address write that has bit 4 set. In that byte, bit 0 requests a mode byte, bit 1 selects single (non-chained) use and bit 3 selects level sensing. The next odd-address writes are taken in a fixed order: vector base, then the cascade byte (skipped in single use), then the mode byte (only when requested). Every odd-address write after that loads the mask, and an odd-address read returns the mask.
- R3: A command at the even address with bit 4 = 0, bit 3 = 1 and bit 1 = 1 selects what even-address reads return. Bit 0 = 0 returns the request register and bit 0 = 1 returns the in-service register. The request register is selected after each start byte.
- R4: A mask bit of 1 keeps its line from raising `int_out` or winning an acknowledge. The line's request is still recorded in the request register.
- R5: `int_out` is high exactly when the highest-ranked unmasked pending line outranks every in-service line. By default line 0 ranks highest and line 7 lowest.
- R6: An acknowledge that finds a winning line sets that line's in-service bit, clears its edge-captured request, and in the next cycle pulses `vec_valid` with `vec_out` = vector base + line number (modulo 256).
- R7: An acknowledge that finds no winner pulses `vec_valid` with vector base + 7 and changes no in-service bit.
- R8: Command 0x20 clears the highest-ranked in-service bit. Command 0x60|n clears in-service bit n. An end-of-interrupt command and an acknowledge in the same cycle both take effect.
- R9: Command 0xC0|n makes line n lowest priority, so line n+1 (mod 8) ranks highest. Command 0xA0 clears the highest-ranked in-service bit and makes that line lowest. Command 0xE0|n clears bit n and makes line n lowest.
- R10: Mode byte bit 1 selects automatic end of interrupt: an acknowledged line is not left in service.
- R11: In edge mode, a request is captured on a low-to-high input transition and held until it is acknowledged. In level mode, the request register follows the inputs each cycle.
- R12: On a chained master (not single use, and not configured as a slave), acknowledging a line whose bit is set in the cascade byte pulses `cas_valid` with `cas_out` = line number instead of `vec_valid`. With mode byte bit 4 set, such a line may interrupt again while it is already in service.
- R13: Mode byte bit 3 = 1 with bit 2 = 0 makes a chained controller a slave whose identity is cascade-byte bits 2:0. A slave ignores an acknowledge unless `cas_in` equals its identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for register writes |
| wr | input | 1 | Write strobe, one cycle per byte |
| a0 | input | 1 | Register address bit (even/odd) |
| din | input | 8 | Write data |
| dout | output | 8 | Read data: mask at odd address, request or in-service at even |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to the processor |
| inta | input | 1 | Acknowledge strobe, one cycle |
| cas_in | input | 3 | Cascade code seen by a slave during acknowledge |
| vec_out | output | 8 | Vector byte, valid with vec_valid |
| vec_valid | output | 1 | One-cycle pulse after an answered acknowledge |
| cas_out | output | 3 | Line number handed to a slave, valid with cas_valid |
| cas_valid | output | 1 | One-cycle pulse when a master defers to its slave |

## Verification
An acknowledge and an end-of-interrupt command can land on the same clock edge: one sets an in-service bit while the other clears the highest-ranked one. The random phase issues both in the same cycle many times, mixed with mask writes, rotations and fresh request edges. After each cycle it compares the vector returned, `int_out`, and periodic readbacks of the in-service and request registers against a bench model. The model applies the clear from the pre-edge state first and then the set. A wrong ordering or a lost update shows up as a wrong in-service readback or as `int_out` raised at the wrong time.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NLINE = 8;
  localparam int LW    = $clog2(NLINE);
  localparam int DW    = 8;

  typedef logic [NLINE-1:0] lvec_t;
  typedef logic [LW-1:0]    line_t;

  typedef enum logic [2:0] {
    IS_IDLE  = 3'd0,
    IS_BASE  = 3'd1,
    IS_CASC  = 3'd2,
    IS_MODE  = 3'd3,
    IS_READY = 3'd4
  } ist_e;

  // rank 0 is the highest priority: the line just above the lowest one
  function automatic line_t rank_of(line_t line, line_t lowest);
    return line_t'(line - lowest - line_t'(1));
  endfunction

  function automatic line_t line_at_rank(line_t rank, line_t lowest);
    return line_t'(lowest + line_t'(1) + rank);
  endfunction

  function automatic logic [DW-1:0] vector_of(logic [DW-1:0] base, line_t line);
    return base + DW'(line);
  endfunction

  function automatic lvec_t onehot(line_t line);
    return lvec_t'(1) << line;
  endfunction
endpackage

// File: rtl/irqc_cmd.sv
module irqc_cmd
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          a0,
  input  logic [DW-1:0] din,
  input  line_t         isr_top,
  input  logic          isr_any,
  output logic          init_go,
  output logic          ready,
  output logic          ltim,
  output logic          sngl,
  output logic          aeoi,
  output logic          sfnm,
  output logic          is_slave,
  output logic          rd_isr,
  output logic [DW-1:0] base,
  output logic [DW-1:0] casc,
  output logic [DW-1:0] imr,
  output line_t         lowest,
  output logic          eoi_ns,
  output logic          eoi_sp,
  output line_t         eoi_line
);
  ist_e       st;
  logic       want_mode;
  logic       slave_q;
  logic       wr_even, wr_odd, cmd_ok, sel_cmd, pri_cmd;
  logic [2:0] op;
  logic       low_we;
  line_t      low_nx;

  assign wr_even = wr_en & ~a0;
  assign wr_odd  = wr_en & a0;
  assign init_go = wr_even & din[4];
  assign ready   = (st == IS_READY);
  assign cmd_ok  = wr_even & ~din[4] & ready;
  assign sel_cmd = cmd_ok & din[3];
  assign pri_cmd = cmd_ok & ~din[3];
  assign op      = din[7:5];

  assign eoi_ns   = pri_cmd & ((op == 3'b001) | (op == 3'b101));
  assign eoi_sp   = pri_cmd & ((op == 3'b011) | (op == 3'b111));
  assign eoi_line = din[LW-1:0];

  always_comb begin
    low_we = 1'b0;
    low_nx = din[LW-1:0];
    if (pri_cmd) begin
      unique case (op)
        3'b110, 3'b111: low_we = 1'b1;
        3'b101: begin
          low_we = isr_any;
          low_nx = isr_top;
        end
        default: low_we = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IS_IDLE;
      want_mode <= 1'b0;
      sngl      <= 1'b0;
      ltim      <= 1'b0;
      aeoi      <= 1'b0;
      sfnm      <= 1'b0;
      slave_q   <= 1'b0;
      base      <= '0;
      casc      <= '0;
      imr       <= '1;
      lowest    <= line_t'(NLINE-1);
      rd_isr    <= 1'b0;
    end else if (init_go) begin
      st        <= IS_BASE;
      want_mode <= din[0];
      sngl      <= din[1];
      ltim      <= din[3];
      aeoi      <= 1'b0;
      sfnm      <= 1'b0;
      slave_q   <= 1'b0;
      casc      <= '0;
      imr       <= '1;
      lowest    <= line_t'(NLINE-1);
      rd_isr    <= 1'b0;
    end else if (wr_odd) begin
      unique case (st)
        IS_BASE: begin
          base <= din;
          if (!sngl)          st <= IS_CASC;
          else if (want_mode) st <= IS_MODE;
          else                st <= IS_READY;
        end
        IS_CASC: begin
          casc <= din;
          st   <= want_mode ? IS_MODE : IS_READY;
        end
        IS_MODE: begin
          aeoi    <= din[1];
          sfnm    <= din[4];
          slave_q <= din[3] & ~din[2];
          st      <= IS_READY;
        end
        IS_READY: imr <= din;
        default: st <= st;
      endcase
    end else begin
      if (sel_cmd && din[1]) rd_isr <= din[0];
      if (low_we)            lowest <= low_nx;
    end
  end

  assign is_slave = slave_q & ~sngl;
endmodule

// File: rtl/irqc_req.sv
module irqc_req
  import irqc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_all,
  input  logic  ltim,
  input  lvec_t irq_in,
  input  lvec_t ack_clr,
  output lvec_t irr
);
  lvec_t prev;
  lvec_t rise;
  lvec_t nxt;

  for (genvar i = 0; i < NLINE; i++) begin : g_line
    assign rise[i] = irq_in[i] & ~prev[i];
    assign nxt[i]  = ltim ? irq_in[i] : (rise[i] | (irr[i] & ~ack_clr[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      irr  <= '0;
    end else begin
      prev <= irq_in;
      irr  <= clr_all ? '0 : nxt;
    end
  end
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve
  import irqc_pkg::*;
(
  input  lvec_t irr,
  input  lvec_t imr,
  input  lvec_t isr,
  input  lvec_t nest_ok,
  input  line_t lowest,
  output line_t req_win,
  output logic  req_any,
  output line_t isr_top,
  output logic  isr_any,
  output logic  int_req
);
  lvec_t pend;
  line_t r_req, r_isr;

  assign pend = irr & ~imr;

  // scan from lowest rank upward so the last hit is the best one
  always_comb begin
    line_t ln;
    req_any = 1'b0;
    req_win = '0;
    isr_any = 1'b0;
    isr_top = '0;
    for (int k = NLINE-1; k >= 0; k--) begin
      ln = line_at_rank(line_t'(k), lowest);
      if (pend[ln]) begin
        req_any = 1'b1;
        req_win = ln;
      end
      if (isr[ln]) begin
        isr_any = 1'b1;
        isr_top = ln;
      end
    end
  end

  assign r_req   = rank_of(req_win, lowest);
  assign r_isr   = rank_of(isr_top, lowest);
  assign int_req = req_any & (~isr_any | (r_req < r_isr) |
                              ((req_win == isr_top) & nest_ok[req_win]));
endmodule

// File: rtl/irqc_svc.sv
module irqc_svc
  import irqc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_all,
  input  lvec_t set_v,
  input  lvec_t clr_v,
  output lvec_t isr
);
  lvec_t nxt;

  for (genvar i = 0; i < NLINE; i++) begin : g_bit
    assign nxt[i] = set_v[i] | (isr[i] & ~clr_v[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       isr <= '0;
    else if (clr_all) isr <= '0;
    else              isr <= nxt;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          wr,
  input  logic          a0,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic [NLINE-1:0] irq_in,
  output logic          int_out,
  input  logic          inta,
  input  logic [LW-1:0] cas_in,
  output logic [DW-1:0] vec_out,
  output logic          vec_valid,
  output logic [LW-1:0] cas_out,
  output logic          cas_valid
);
  logic          wr_en, init_go, ready, ltim, sngl, aeoi, sfnm, is_slave, rd_isr;
  logic [DW-1:0] base, casc, imr_q;
  line_t         lowest, eoi_line, req_win, isr_top, ack_line;
  logic          eoi_ns, eoi_sp, req_any, isr_any, int_req;
  lvec_t         irr_q, isr_q, nest_ok, isr_set, isr_clr, irr_clr;
  logic          ack_take, ack_real, to_slave, vec_fire;

  assign wr_en = cs & wr;

  irqc_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .din(din),
    .isr_top(isr_top), .isr_any(isr_any),
    .init_go(init_go), .ready(ready), .ltim(ltim), .sngl(sngl), .aeoi(aeoi),
    .sfnm(sfnm), .is_slave(is_slave), .rd_isr(rd_isr),
    .base(base), .casc(casc), .imr(imr_q), .lowest(lowest),
    .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_line(eoi_line)
  );

  irqc_req u_req (
    .clk(clk), .rst_n(rst_n), .clr_all(init_go), .ltim(ltim),
    .irq_in(irq_in), .ack_clr(irr_clr), .irr(irr_q)
  );

  assign nest_ok = (sfnm & ~sngl & ~is_slave) ? casc : '0;

  irqc_resolve u_res (
    .irr(irr_q), .imr(imr_q), .isr(isr_q), .nest_ok(nest_ok), .lowest(lowest),
    .req_win(req_win), .req_any(req_any), .isr_top(isr_top), .isr_any(isr_any),
    .int_req(int_req)
  );

  // acknowledge: a slave only answers its own cascade code
  assign ack_take = inta & ready & (~is_slave | (cas_in == casc[LW-1:0]));
  assign ack_real = ack_take & int_req;
  assign ack_line = ack_real ? req_win : line_t'(NLINE-1);
  assign to_slave = ack_real & ~sngl & ~is_slave & casc[req_win];
  assign vec_fire = ack_take & ~to_slave;

  assign isr_set = (ack_real & ~aeoi) ? onehot(req_win) : '0;
  assign irr_clr = ack_real ? onehot(req_win) : '0;
  assign isr_clr = (eoi_ns & isr_any) ? onehot(isr_top) :
                   eoi_sp             ? onehot(eoi_line) : '0;

  irqc_svc u_svc (
    .clk(clk), .rst_n(rst_n), .clr_all(init_go),
    .set_v(isr_set), .clr_v(isr_clr), .isr(isr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_out   <= '0;
      vec_valid <= 1'b0;
      cas_out   <= '0;
      cas_valid <= 1'b0;
    end else begin
      vec_valid <= vec_fire;
      cas_valid <= to_slave;
      if (vec_fire) vec_out <= vector_of(base, ack_line);
      if (to_slave) cas_out <= req_win;
    end
  end

  assign int_out = ready & int_req;
  assign dout    = a0 ? imr_q : (rd_isr ? isr_q : irr_q);

  logic unused_ok;
  assign unused_ok = req_any;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import irqc_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  inta,
  input logic  int_out,
  input logic  vec_valid,
  input logic  cas_valid,
  input logic  ready,
  input logic  aeoi,
  input logic  ack_real,
  input logic  eoi_ns,
  input logic  isr_any,
  input logic  init_go,
  input lvec_t irr,
  input lvec_t imr,
  input lvec_t isr,
  input line_t req_win,
  input line_t isr_top
);
  assert_quiet_until_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);

  assert_int_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != '0));

  assert_reply_follows_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid || cas_valid) |-> $past(inta));

  assert_ack_marks_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_real && !aeoi && !init_go) |=> isr[$past(req_win)]);

  assert_single_reply_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && cas_valid));

  assert_auto_end_no_growth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_real && aeoi) |=> ($countones(isr) <= $countones($past(isr))));

  assert_plain_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ns && isr_any && !ack_real) |=> !isr[$past(isr_top)]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta), .int_out(int_out),
  .vec_valid(vec_valid), .cas_valid(cas_valid), .ready(ready), .aeoi(aeoi),
  .ack_real(ack_real), .eoi_ns(eoi_ns), .isr_any(isr_any), .init_go(init_go),
  .irr(irr_q), .imr(imr_q), .isr(isr_q), .req_win(req_win), .isr_top(isr_top)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0, a0 = 1'b0, inta = 1'b0;
  logic [7:0] din = 8'h00, irq = 8'h00;
  logic [2:0] cas_in = 3'd0;
  logic [7:0] dout, vec_out;
  logic       int_out, vec_valid, cas_valid;
  logic [2:0] cas_out;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .a0(a0), .din(din), .dout(dout),
    .irq_in(irq), .int_out(int_out), .inta(inta), .cas_in(cas_in),
    .vec_out(vec_out), .vec_valid(vec_valid), .cas_out(cas_out), .cas_valid(cas_valid)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic adr, input logic [7:0] d);
    cs = 1'b1; wr = 1'b1; a0 = adr; din = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic ack(input logic [2:0] code);
    inta = 1'b1; cas_in = code;
    @(negedge clk);
    inta = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    irq = v;
    @(negedge clk);
  endtask

  task automatic rd(input logic adr, output logic [7:0] v);
    a0 = adr;
    #1;
    v = dout;
  endtask

  task automatic init_pic(input logic [7:0] w1, input logic [7:0] vb,
                          input logic [7:0] cc, input logic [7:0] md);
    wr_cmd(1'b0, w1);
    wr_cmd(1'b1, vb);
    if (!w1[1]) wr_cmd(1'b1, cc);
    if (w1[0])  wr_cmd(1'b1, md);
  endtask

  // priority model: walk lines from just above the lowest one
  function automatic int f_best(input logic [7:0] v, input int low);
    for (int k = 0; k < 8; k++) begin
      int ln;
      ln = (low + 1 + k) % 8;
      if (v[ln]) return ln;
    end
    return -1;
  endfunction

  function automatic logic f_int(input logic [7:0] r, input logic [7:0] m,
                                 input logic [7:0] s, input int low);
    int p, q;
    p = f_best(r & ~m, low);
    q = f_best(s, low);
    if (p < 0) return 1'b0;
    if (q < 0) return 1'b1;
    return ((p - low + 7) % 8) < ((q - low + 7) % 8);
  endfunction

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] m_irr, m_isr, m_imr, m_prev, nirq, d, set_v, aclr, clr, expv;
    int m_low, op, b, s;
    logic ie, do_ack, do_wr, wa;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 int low at reset", int_out, 0);
    rd(1'b1, v); chk("R1 mask at reset", v, 8'hFF);
    chk("R1 no vector at reset", vec_valid, 0);
    set_irq(8'h01);
    chk("R1 no int before config", int_out, 0);
    set_irq(8'h00);

    // R2 single use with mode byte
    init_pic(8'h13, 8'h40, 8'h00, 8'h01);
    rd(1'b1, v); chk("R1 mask after start byte", v, 8'hFF);
    wr_cmd(1'b1, 8'hF7);
    rd(1'b1, v); chk("R2 mask load", v, 8'hF7);

    // R5/R3 line 3 request
    set_irq(8'h08);
    chk("R5 int on unmasked line", int_out, 1);
    rd(1'b0, v); chk("R3 request readback", v, 8'h08);
    ack(3'd0);
    chk("R6 vector valid", vec_valid, 1);
    chk("R6 vector value", vec_out, 8'h43);
    chk("R5 int drops while in service", int_out, 0);
    wr_cmd(1'b0, 8'h0B);
    rd(1'b0, v); chk("R3 in-service readback", v, 8'h08);
    wr_cmd(1'b0, 8'h0A);
    rd(1'b0, v); chk("R11 edge request cleared by ack", v, 8'h00);

    // R4 masked line recorded only
    set_irq(8'h0A);
    chk("R4 masked line no int", int_out, 0);
    rd(1'b0, v); chk("R4 masked line recorded", v, 8'h02);

    // R5 nesting
    wr_cmd(1'b1, 8'h00);
    chk("R5 higher line nests", int_out, 1);
    ack(3'd0);
    chk("R6 nested vector", vec_out, 8'h41);
    set_irq(8'h4A);
    chk("R5 lower line waits", int_out, 0);

    // R8 end of interrupt forms
    wr_cmd(1'b0, 8'h20);
    wr_cmd(1'b0, 8'h0B);
    rd(1'b0, v); chk("R8 plain eoi clears top", v, 8'h08);
    chk("R5 line 6 below line 3", int_out, 0);
    wr_cmd(1'b0, 8'h63);
    chk("R8 specific eoi frees line 6", int_out, 1);
    ack(3'd0);
    chk("R6 vector line 6", vec_out, 8'h46);
    wr_cmd(1'b0, 8'h20);
    rd(1'b0, v); chk("R8 service empty", v, 8'h00);

    // R7 spurious acknowledge
    ack(3'd0);
    chk("R7 spurious valid", vec_valid, 1);
    chk("R7 spurious vector", vec_out, 8'h47);
    rd(1'b0, v); chk("R7 service untouched", v, 8'h00);

    // R9 rotation
    wr_cmd(1'b0, 8'hC2);
    set_irq(8'h00);
    set_irq(8'h09);
    ack(3'd0);
    chk("R9 line 3 first after lowest=2", vec_out, 8'h43);
    chk("R9 line 0 ranks below 3", int_out, 0);
    wr_cmd(1'b0, 8'hA0);
    chk("R9 rotate eoi releases line 0", int_out, 1);
    ack(3'd0);
    chk("R9 vector line 0", vec_out, 8'h40);
    wr_cmd(1'b0, 8'hE0);
    rd(1'b0, v); chk("R9 specific rotate clears", v, 8'h00);
    set_irq(8'h82);
    ack(3'd0);
    chk("R9 line 1 highest after lowest=0", vec_out, 8'h41);
    wr_cmd(1'b0, 8'h20);
    ack(3'd0);
    chk("R9 then line 7", vec_out, 8'h47);
    wr_cmd(1'b0, 8'h20);

    // R10 automatic end of interrupt
    set_irq(8'h00);
    init_pic(8'h13, 8'h40, 8'h00, 8'h03);
    wr_cmd(1'b1, 8'h00);
    set_irq(8'h10);
    ack(3'd0);
    chk("R10 vector", vec_out, 8'h44);
    wr_cmd(1'b0, 8'h0B);
    rd(1'b0, v); chk("R10 not left in service", v, 8'h00);

    // R11 level sensing
    set_irq(8'h00);
    init_pic(8'h1B, 8'h40, 8'h00, 8'h01);
    wr_cmd(1'b1, 8'h00);
    set_irq(8'h20);
    chk("R11 level raises int", int_out, 1);
    set_irq(8'h00);
    chk("R11 level drop removes int", int_out, 0);
    set_irq(8'h20);
    ack(3'd0);
    chk("R11 level vector", vec_out, 8'h45);
    chk("R11 in service blocks", int_out, 0);
    wr_cmd(1'b0, 8'h20);
    chk("R11 still high re-requests", int_out, 1);

    // R12 chained master
    set_irq(8'h00);
    init_pic(8'h11, 8'h08, 8'h04, 8'h1D);
    wr_cmd(1'b1, 8'h00);
    set_irq(8'h04);
    ack(3'd0);
    chk("R12 cascade pulse", cas_valid, 1);
    chk("R12 cascade line", cas_out, 3'd2);
    chk("R12 no vector from master", vec_valid, 0);
    set_irq(8'h00);
    set_irq(8'h04);
    chk("R12 nested same slave line", int_out, 1);
    wr_cmd(1'b0, 8'h20);

    // R13 slave
    set_irq(8'h00);
    init_pic(8'h11, 8'h70, 8'h02, 8'h09);
    wr_cmd(1'b1, 8'h00);
    set_irq(8'h10);
    chk("R13 slave requests", int_out, 1);
    ack(3'd1);
    chk("R13 other code ignored", vec_valid, 0);
    wr_cmd(1'b0, 8'h0B);
    rd(1'b0, v); chk("R13 service untouched", v, 8'h00);
    ack(3'd2);
    chk("R13 own code answered", vec_valid, 1);
    chk("R13 slave vector", vec_out, 8'h74);

    // R2 no mode byte
    set_irq(8'h00);
    init_pic(8'h12, 8'h50, 8'h00, 8'h00);
    wr_cmd(1'b1, 8'hA5);
    rd(1'b1, v); chk("R2 short sequence then mask", v, 8'hA5);

    // random phase, single use, edge mode
    init_pic(8'h13, 8'h80, 8'h00, 8'h01);
    m_irr = 8'h00; m_isr = 8'h00; m_imr = 8'hFF; m_prev = 8'h00; m_low = 7;
    for (int it = 0; it < 400; it++) begin
      op   = int'($urandom % 8);
      nirq = (($urandom % 4) == 0) ? 8'($urandom) : irq;
      do_ack = (op == 1) || (op == 6);
      do_wr  = 1'b1; wa = 1'b0; d = 8'h00;
      case (op)
        2: begin wa = 1'b1; d = 8'($urandom) & 8'($urandom); end
        3, 6: d = 8'h20;
        4: d = 8'h60 | 8'($urandom % 8);
        5: d = 8'hC0 | 8'($urandom % 8);
        7: d = 8'hA0;
        default: do_wr = 1'b0;
      endcase
      b  = f_best(m_irr & ~m_imr, m_low);
      ie = f_int(m_irr, m_imr, m_isr, m_low);
      set_v = 8'h00; aclr = 8'h00; clr = 8'h00; expv = 8'h87;
      if (do_ack && ie) begin
        expv  = 8'h80 + 8'(b);
        set_v = 8'h01 << b;
        aclr  = 8'h01 << b;
      end
      if (op == 3 || op == 6 || op == 7) begin
        s = f_best(m_isr, m_low);
        if (s >= 0) begin
          clr = 8'h01 << s;
          if (op == 7) m_low = s;
        end
      end
      if (op == 4) clr = 8'h01 << d[2:0];
      if (op == 5) m_low = int'(d[2:0]);
      if (op == 2) m_imr = d;
      irq = nirq;
      if (do_wr) begin cs = 1'b1; wr = 1'b1; a0 = wa; din = d; end
      if (do_ack) begin inta = 1'b1; cas_in = 3'd0; end
      m_isr  = (m_isr & ~clr) | set_v;
      m_irr  = (m_irr & ~aclr) | (nirq & ~m_prev);
      m_prev = nirq;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0; inta = 1'b0;
      if (do_ack) begin
        chk("R6 random ack valid", vec_valid, 1);
        chk("R6 random vector", vec_out, expv);
      end else begin
        chk("R6 no vector without ack", vec_valid, 0);
      end
      chk("R5 random int", int_out, f_int(m_irr, m_imr, m_isr, m_low));
      if ((it % 50) == 49) begin
        wr_cmd(1'b0, 8'h0B);
        rd(1'b0, v); chk("R8 random in-service", v, m_isr);
        wr_cmd(1'b0, 8'h0A);
        rd(1'b0, v); chk("R3 random request", v, m_irr);
      end
    end

    done = 1'b1;
    finish_up();
  end
endmodule